// File: doc/BRIEF.md
# Tick Compare Timer with Disable Bit

This block is a processor-side timer. It holds a free-running 63-bit count and a 63-bit limit. A single disabled flag sits beside them in the top bit of the 64-bit register word. Software reaches the block through a write port that takes either the count or the limit, selected by one bit. A read port continuously shows the count with the disabled flag in bit 63. On every clock the count moves up by a fixed step, which stands in for clock-frequency scaling.

Writing a limit arms a one-shot match. The match is not armed if the limit is zero or if the written word has bit 63 set. The first clock edge that finds the armed count at or above the limit consumes the match. If the timer was enabled on that edge, the block gives a one-cycle set request on one bit of a software-interrupt vector, together with a wake request to the core. A parameter selects the bit: the main-timer bit or the system-timer bit. If the timer was disabled, the match is consumed and nothing is signalled.

The register port has no back-pressure. It accepts a write on every cycle where `reg_wr` is high. No stream data crosses the block boundary, so all pins are plain control and status.

Top module: `tick_cmp_timer`

## Requirements
- R1: While reset is held, `count_rdata` reads 0x8000_0000_0000_0000 (disabled, count zero), and `softint_set` and `wake_req` are zero.
- R2: A write with `reg_sel`=0 loads bits 62:0 into the count and sets the disabled flag from bit 63. In the cycle after the write, `count_rdata` equals the written word.
- R3: When no count write occurs, the count advances by `CNT_STEP` (default 1) on every clock edge. It wraps modulo 2^63.
- R4: A write with `reg_sel`=1 loads bits 62:0 into the limit and sets the disabled flag from bit 63. From the next cycle, the flag shows as bit 63 of `count_rdata`.
- R5: A limit write whose bits 62:0 are zero arms nothing and cancels any pending match.
- R6: A limit write with bit 63 set cancels any pending match, even if its bits 62:0 are nonzero.
- R7: If the written limit is at or below the count present at the next edge, the match fires on that next edge and is not lost.
- R8: A match on an enabled timer gives a single-cycle pulse on `wake_req` and on exactly one bit of `softint_set`, once per arming. The pulse is high in the cycle after the first edge at which the armed count (value before the edge) is at or above the limit. A limit write on an edge takes priority over a match on that same edge.
- R9: A match on a timer that was disabled on the matching edge raises nothing and consumes the arming. Re-enabling the timer later does not bring the match back.
- R10: Reset sets the disabled flag and cancels any armed match.
- R11: With `TIMER_KIND` = main, the pulse goes on `softint_set[TICK_BIT]` (default 0). With any other kind it goes on `softint_set[STICK_BIT]` (default 16). No other bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the count, 1 selects the limit |
| reg_wdata | input | TW (64) | Write word; bit 63 is the disable bit |
| count_rdata | output | TW (64) | Running count with the disabled flag in bit 63 |
| softint_set | output | SW (17) | One-cycle set request for the software-interrupt bit |
| wake_req | output | 1 | One-cycle wake request to the core, coincident with the set request |

## Verification
The checks on count stepping and count loading assume `reg_sel` and `reg_wdata` are defined whenever `reg_wr` is high. They also assume the step relation is measured only on cycles with no count write. The bench meets this by driving every write field together on the falling edge and lowering `reg_wr` one cycle later. The no-pulse checks after a zero or disabled limit rely on the fact that no other limit write comes in the following cycle. The bench separates each write from the next one with a full cycle, or it makes back-to-back writes whose effect it predicts explicitly.

// File: rtl/tct_pkg.sv
package tct_pkg;
  // register selector on the write port
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } tct_sel_e;

  // which interrupt bit a timer instance drives
  typedef enum logic {
    KIND_MAIN   = 1'b0,
    KIND_SYSTEM = 1'b1
  } tct_kind_e;
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CW       = 63,
  parameter int CNT_STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] STEP_V = CW'(CNT_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= cnt + STEP_V;
  end
endmodule

// File: rtl/tct_match.sv
module tct_match #(
  parameter int CW = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          dis,
  input  logic          lim_wr,
  input  logic [CW-1:0] lim_val,
  input  logic          lim_dis,
  output logic          fire
);
  logic [CW-1:0] lim_q;
  logic          armed_q;
  logic          hit;

  // one-shot compare: at or above covers a limit written behind the count
  assign hit = armed_q && (cnt >= lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q   <= '0;
      armed_q <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (lim_wr) begin
        lim_q   <= lim_val;
        armed_q <= (lim_val != '0) && !lim_dis;
      end else if (hit) begin
        armed_q <= 1'b0;
        fire    <= !dis;
      end
    end
  end
endmodule

// File: rtl/tct_irq_route.sv
module tct_irq_route #(
  parameter int                  SW         = 17,
  parameter int                  TICK_BIT   = 0,
  parameter int                  STICK_BIT  = 16,
  parameter tct_pkg::tct_kind_e  TIMER_KIND = tct_pkg::KIND_MAIN
) (
  input  logic          fire,
  output logic [SW-1:0] softint_set,
  output logic          wake_req
);
  localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

  if (TIMER_KIND == tct_pkg::KIND_MAIN) begin : g_main
    assign softint_set = fire ? (ONE << TICK_BIT) : '0;
  end else begin : g_sys
    assign softint_set = fire ? (ONE << STICK_BIT) : '0;
  end

  assign wake_req = fire;
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int                  TW         = 64,
  parameter int                  CNT_STEP   = 1,
  parameter int                  SW         = 17,
  parameter int                  TICK_BIT   = 0,
  parameter int                  STICK_BIT  = 16,
  parameter tct_pkg::tct_kind_e  TIMER_KIND = tct_pkg::KIND_MAIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [TW-1:0] reg_wdata,
  output logic [TW-1:0] count_rdata,
  output logic [SW-1:0] softint_set,
  output logic          wake_req
);
  localparam int CW = TW - 1;

  logic          wr_count;
  logic          wr_limit;
  logic          dis_q;
  logic [CW-1:0] cnt;
  logic          fire;

  assign wr_count = reg_wr && (reg_sel == tct_pkg::SEL_COUNT);
  assign wr_limit = reg_wr && (reg_sel == tct_pkg::SEL_LIMIT);

  // disabled flag: either register write carries it in its top bit
  always_ff @(posedge clk) begin
    if (!rst_n)      dis_q <= 1'b1;
    else if (reg_wr) dis_q <= reg_wdata[TW-1];
  end

  tct_counter #(.CW(CW), .CNT_STEP(CNT_STEP)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_count),
    .load_val (reg_wdata[CW-1:0]),
    .cnt      (cnt)
  );

  tct_match #(.CW(CW)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .dis     (dis_q),
    .lim_wr  (wr_limit),
    .lim_val (reg_wdata[CW-1:0]),
    .lim_dis (reg_wdata[TW-1]),
    .fire    (fire)
  );

  tct_irq_route #(
    .SW(SW), .TICK_BIT(TICK_BIT), .STICK_BIT(STICK_BIT), .TIMER_KIND(TIMER_KIND)
  ) u_route (
    .fire        (fire),
    .softint_set (softint_set),
    .wake_req    (wake_req)
  );

  assign count_rdata = {dis_q, cnt};
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int TW       = 64,
  parameter int SW       = 17,
  parameter int CNT_STEP = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic [TW-1:0] reg_wdata,
  input logic [TW-1:0] count_rdata,
  input logic [SW-1:0] softint_set,
  input logic          wake_req
);
  localparam int CW = TW - 1;

  // R2: a count write shows up verbatim on the read port next cycle
  a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 1'b0) |=> (count_rdata == $past(reg_wdata)));

  // R3: without a count write the count moves by the step
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == 1'b0) |=>
      (count_rdata[CW-1:0] == $past(count_rdata[CW-1:0]) + CW'(CNT_STEP)));

  // R5: a zero limit never produces a pulse on the following cycle
  a_r5_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 1'b1 && reg_wdata[CW-1:0] == '0) |=> !wake_req);

  // R6: a limit written with the disable bit produces no pulse next cycle
  a_r6_dis_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 1'b1 && reg_wdata[TW-1]) |=> !wake_req);

  // R8: pulses last one cycle and set at most one interrupt bit
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(softint_set));

  // R9: no pulse can follow a cycle in which the timer read as disabled
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !$past(count_rdata[TW-1]));
endmodule

bind tick_cmp_timer tct_checker #(.TW(TW), .SW(SW), .CNT_STEP(CNT_STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .count_rdata (count_rdata),
  .softint_set (softint_set),
  .wake_req    (wake_req)
);

// File: tb/tick_cmp_timer_test.sv
module tick_cmp_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 64;
  localparam int SW = 17;
  localparam int NV = 6;

  // vectors: count loaded, limit written next cycle, count read at the pulse
  localparam logic [63:0] VEC_CNT [NV] = '{64'd100, 64'd0, 64'd500, 64'd1000,
                                           64'd1099511627776, 64'd7};
  localparam logic [63:0] VEC_LIM [NV] = '{64'd110, 64'd1, 64'd300, 64'd1001,
                                           64'd1099511627796, 64'd50};
  localparam logic [63:0] VEC_EXP [NV] = '{64'd111, 64'd2, 64'd502, 64'd1002,
                                           64'd1099511627797, 64'd51};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [TW-1:0] reg_wdata = '0;
  logic [TW-1:0] count_rdata, count_rdata2;
  logic [SW-1:0] softint_set, softint_set2;
  logic          wake_req, wake_req2;

  int checks = 0;
  int failures = 0;

  tick_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .count_rdata(count_rdata),
    .softint_set(softint_set), .wake_req(wake_req)
  );

  tick_cmp_timer #(.TIMER_KIND(tct_pkg::KIND_SYSTEM)) uut_sys (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .count_rdata(count_rdata2),
    .softint_set(softint_set2), .wake_req(wake_req2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic sel, input logic [63:0] data);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic watch(input int n, output int pulses, output logic [63:0] c_at,
                       output logic [SW-1:0] si, output logic [SW-1:0] si2);
    pulses = 0; c_at = '0; si = '0; si2 = '0;
    for (int i = 0; i < n; i++) begin
      if (wake_req) begin
        pulses++;
        if (pulses == 1) begin
          c_at = count_rdata; si = softint_set; si2 = softint_set2;
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int np;
    logic [63:0] cat, cur, a, b;
    logic [SW-1:0] s1, s2;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(count_rdata == 64'h8000_0000_0000_0000, "R1 reset count", count_rdata,
        64'h8000_0000_0000_0000);
    chk(softint_set == '0 && !wake_req, "R1 reset outputs", 64'(softint_set), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, VEC_CNT[v]);
      wr(1'b1, VEC_LIM[v]);
      watch(80, np, cat, s1, s2);
      chk(np == 1, "R8 one pulse per arming", 64'(np), 64'd1);
      chk(cat == VEC_EXP[v], "R7/R8 count at pulse", cat, VEC_EXP[v]);
      chk(s1 == 17'h00001, "R11 main bit", 64'(s1), 64'h1);
      chk(s2 == 17'h10000, "R11 system bit", 64'(s2), 64'h10000);
    end

    // R2 and R3: load and stepping, enabled and disabled
    wr(1'b0, 64'd4242);
    chk(count_rdata == 64'd4242, "R2 count load", count_rdata, 64'd4242);
    a = count_rdata; @(negedge clk); b = count_rdata;
    chk(b == a + 64'd1, "R3 step", b, a + 64'd1);
    chk(count_rdata2 == count_rdata, "R11 twin count", count_rdata2, count_rdata);
    wr(1'b0, 64'h8000_0000_0000_0005);
    chk(count_rdata == 64'h8000_0000_0000_0005, "R2 disabled load", count_rdata,
        64'h8000_0000_0000_0005);
    @(negedge clk);
    chk(count_rdata == 64'h8000_0000_0000_0006, "R3 step disabled", count_rdata,
        64'h8000_0000_0000_0006);

    // R4: limit writes drive the disabled flag
    wr(1'b1, 64'd0);
    chk(count_rdata[63] == 1'b0, "R4 limit clears flag", 64'(count_rdata[63]), 64'd0);
    wr(1'b1, 64'h8000_0000_0000_03E7);
    chk(count_rdata[63] == 1'b1, "R4 limit sets flag", 64'(count_rdata[63]), 64'd1);

    // R5: zero limit cancels a pending match
    wr(1'b0, 64'd3000);
    cur = count_rdata;
    wr(1'b1, cur + 64'd10);
    wr(1'b1, 64'd0);
    watch(40, np, cat, s1, s2);
    chk(np == 0, "R5 zero limit cancels", 64'(np), 64'd0);

    // R6: limit with disable bit cancels a pending match
    cur = count_rdata;
    wr(1'b1, cur + 64'd10);
    wr(1'b1, 64'h8000_0000_0000_0000 | (cur + 64'd12));
    watch(40, np, cat, s1, s2);
    chk(np == 0, "R6 disabled limit cancels", 64'(np), 64'd0);
    chk(count_rdata[63] == 1'b1, "R6 flag set", 64'(count_rdata[63]), 64'd1);

    // R9: match while disabled is silent and consumed
    wr(1'b0, 64'd1000);
    wr(1'b1, 64'd1010);
    wr(1'b0, 64'h8000_0000_0000_03E8);
    watch(40, np, cat, s1, s2);
    chk(np == 0, "R9 silent while disabled", 64'(np), 64'd0);
    wr(1'b0, 64'd1000);
    watch(40, np, cat, s1, s2);
    chk(np == 0, "R9 match consumed", 64'(np), 64'd0);

    // R10: reset cancels an armed match and disables
    wr(1'b0, 64'd2000);
    wr(1'b1, 64'd2020);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(count_rdata[63] == 1'b1, "R10 reset disables", 64'(count_rdata[63]), 64'd1);
    wr(1'b0, 64'd5);
    watch(40, np, cat, s1, s2);
    chk(np == 0, "R10 reset cancels arming", 64'(np), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule